// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that lives in memory. The page size is 1 KB, so the low 10 bits of the address are the byte offset and pass through unchanged. The 22-bit page number is split in two. The upper 12 bits select an entry in the first-level table, and that entry holds the frame of a second-level table. The lower 10 bits select the leaf entry in that second-level table. The leaf holds the target frame together with its access flags.

Each walk starts when a request is accepted. A request carries a virtual address and an access kind (read, write or execute). The walker reads the first-level table from the base given on the `ptbr` pin, which is sampled when the request is accepted. It then makes two dependent reads on a single memory read port. The walk ends with one response: either a physical address or a fault with its cause.

The walker never writes a table entry. When a write succeeds on a page whose modified flag is still clear, it raises an update request that names the leaf entry's address, so that other logic can set that flag. Filling in missing pages and copying copy-on-write pages are left to software after a fault.

All three data interfaces use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no walk is in flight. A memory read is issued on an edge where `mem_rd_valid` and `mem_rd_ready` are both high, and the memory may stall it for any number of cycles. The read data comes back later as a one-cycle `mem_rsp_valid` pulse, which the walker always accepts. A response stays on the port, unchanged, until the edge where `rsp_ready` is high.

Top module: `pt_walker`

## Requirements
- R1: A successful translation returns a physical address equal to bits 31:10 of the leaf entry (the frame) joined to the request's address bits 9:0.
- R2: The first read goes to `ptbr` + 4 × (address bits 31:20), using the `ptbr` value sampled on the acceptance edge. Later changes to `ptbr` do not affect a walk in flight.
- R3: The second read goes to (first-level entry bits 31:10) × 1024 + 4 × (address bits 19:10).
- R4: If bit 0 (valid) of the first-level entry is clear, the walk ends with cause 1 after exactly one memory read.
- R5: If bit 0 (valid) of the leaf entry is clear, the walk ends with cause 2.
- R6: Access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. An access that the leaf does not allow ends with cause 3. Bit 1 allows read, bit 2 allows write and bit 3 allows execute. Code 3 is never allowed.
- R7: A write to a valid leaf with bit 5 (copy-on-write) set ends with cause 4, whatever bits 1 and 2 hold. Copy-on-write is checked before the write-permission bit.
- R8: `upd_valid` is high while the response is presented only when the response is a successful write and bit 4 (modified) of the leaf is clear. At that time `upd_addr` equals the leaf entry address.
- R9: Only one walk is in flight at a time. A memory read request keeps its address stable until it is accepted, and a response keeps its contents stable until it is accepted.
- R10: Cause 0 means success. Any faulting response (cause 1 to 4) returns a physical address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Byte address of the first-level table; sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_valid | output | 1 | Table-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying the read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 32 | Physical address, or zero on a fault |
| rsp_fault | output | 3 | Cause: 0 none, 1 first level invalid, 2 leaf invalid, 3 protection, 4 copy-on-write |
| upd_valid | output | 1 | Request to set the modified flag of the leaf |
| upd_addr | output | 32 | Address of the leaf entry to update |

## Verification
The hardest case to reach from the ports is a change of `ptbr` while the walk is in flight and the memory is stalling. In that case only the first read's address shows whether the sampled base was used. The bench changes `ptbr` on the cycle after acceptance, and a memory model inserts random wait cycles before accepting a read and before returning its data. Directed leaf flag sets cover the ordering of copy-on-write ahead of write permission, the reserved access code and the modified-flag update. Random tables are rebuilt for every walk, so both levels are invalid at a steady rate.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 10;
  localparam int IDX1_W    = 12;
  localparam int IDX2_W    = VA_W - OFF_W - IDX1_W;
  localparam int FRM_W     = VA_W - OFF_W;
  localparam int ENT_W     = 32;
  localparam int PTE_SHIFT = 2;
  localparam int FLAG_W    = 6;
  localparam int RSVD_W    = ENT_W - FRM_W - FLAG_W;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_M = 4;
  localparam int B_C = 5;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_L1   = 3'd1,
    FLT_L2   = 3'd2,
    FLT_PROT = 3'd3,
    FLT_COW  = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_L1,
    S_WAIT_L1,
    S_FETCH_L2,
    S_WAIT_L2,
    S_DONE
  } walk_e;

  typedef struct packed {
    logic [FRM_W-1:0]  frame;
    logic [RSVD_W-1:0] rsvd;
    logic [FLAG_W-1:0] flags;
  } pte_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  base,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [FRM_W-1:0] l1_frame,
  output logic [VA_W-1:0]  l1_addr,
  output logic [VA_W-1:0]  l2_addr
);
  localparam int I1_LO = OFF_W + IDX2_W;

  logic [IDX1_W-1:0] idx1;
  logic [IDX2_W-1:0] idx2;

  assign idx1 = vaddr[VA_W-1:I1_LO];
  assign idx2 = vaddr[I1_LO-1:OFF_W];

  // Entries are 4 bytes, so each index is scaled by a left shift.
  assign l1_addr = base + VA_W'({idx1, {PTE_SHIFT{1'b0}}});
  assign l2_addr = {l1_frame, {OFF_W{1'b0}}} + VA_W'({idx2, {PTE_SHIFT{1'b0}}});
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  acc_e              acc,
  output fault_e            cause,
  output logic              need_upd
);
  logic allowed;

  always_comb begin
    unique case (acc)
      ACC_RD:  allowed = flags[B_R];
      ACC_WR:  allowed = flags[B_W];
      ACC_EX:  allowed = flags[B_X];
      default: allowed = 1'b0;
    endcase
  end

  // Order of checks: leaf valid, then copy-on-write on writes, then permission.
  always_comb begin
    if (!flags[B_V])                      cause = FLT_L2;
    else if (acc == ACC_WR && flags[B_C]) cause = FLT_COW;
    else if (!allowed)                    cause = FLT_PROT;
    else                                  cause = FLT_NONE;
  end

  assign need_upd = (cause == FLT_NONE) && (acc == ACC_WR) && !flags[B_M];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_fault,
  output logic             upd_valid,
  output logic [VA_W-1:0]  upd_addr
);
  walk_e            state;
  logic [VA_W-1:0]  vaddr_q;
  logic [VA_W-1:0]  base_q;
  acc_e             acc_q;
  logic [FRM_W-1:0] l1_frame_q;
  logic [VA_W-1:0]  paddr_q;
  fault_e           fault_q;
  logic             upd_q;

  pte_t             pte;
  logic [VA_W-1:0]  l1_addr;
  logic [VA_W-1:0]  l2_addr;
  fault_e           leaf_cause;
  logic             leaf_upd;
  logic             unused_pte;

  assign pte        = pte_t'(mem_rsp_data);
  assign unused_pte = ^pte.rsvd;

  ptw_addr_gen u_addr (
    .base     (base_q),
    .vaddr    (vaddr_q),
    .l1_frame (l1_frame_q),
    .l1_addr  (l1_addr),
    .l2_addr  (l2_addr)
  );

  ptw_perm_check u_perm (
    .flags    (pte.flags),
    .acc      (acc_q),
    .cause    (leaf_cause),
    .need_upd (leaf_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      vaddr_q    <= '0;
      base_q     <= '0;
      acc_q      <= ACC_RD;
      l1_frame_q <= '0;
      paddr_q    <= '0;
      fault_q    <= FLT_NONE;
      upd_q      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            base_q  <= ptbr;
            acc_q   <= acc_e'(req_acc);
            state   <= S_FETCH_L1;
          end
        end
        S_FETCH_L1: if (mem_rd_ready) state <= S_WAIT_L1;
        S_WAIT_L1: begin
          if (mem_rsp_valid) begin
            if (!pte.flags[B_V]) begin
              fault_q <= FLT_L1;
              paddr_q <= '0;
              upd_q   <= 1'b0;
              state   <= S_DONE;
            end else begin
              l1_frame_q <= pte.frame;
              state      <= S_FETCH_L2;
            end
          end
        end
        S_FETCH_L2: if (mem_rd_ready) state <= S_WAIT_L2;
        S_WAIT_L2: begin
          if (mem_rsp_valid) begin
            fault_q <= leaf_cause;
            paddr_q <= (leaf_cause == FLT_NONE) ? {pte.frame, vaddr_q[OFF_W-1:0]} : '0;
            upd_q   <= leaf_upd;
            state   <= S_DONE;
          end
        end
        S_DONE: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FETCH_L1) || (state == S_FETCH_L2);
  assign mem_rd_addr  = (state == S_FETCH_L2) ? l2_addr : l1_addr;
  assign rsp_valid    = (state == S_DONE);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign upd_valid    = (state == S_DONE) && upd_q;
  assign upd_addr     = l2_addr;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
  import ptw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [VA_W-1:0] mem_rd_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_fault,
  input logic            upd_valid
);
  logic [OFF_W-1:0] off_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                      off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_vaddr[OFF_W-1:0];
  end

  // R9: a stalled read keeps its request and its address
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R9: a stalled response keeps its contents
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9: no new request is taken while a walk is active
  p_one_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid && !rsp_valid);

  // R10: a faulting response carries a zero address
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_paddr == '0);

  // R8: an update request appears only alongside a successful response
  p_upd_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> rsp_valid && rsp_fault == 3'd0);

  // R6: the cause code stays within its defined range
  p_cause_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4);

  // R1: the offset of a successful translation equals the accepted request's offset
  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_paddr[OFF_W-1:0] == off_seen);
endmodule

bind pt_walker ptw_checker u_chk (.*);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ptbr;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        upd_valid;
  logic [31:0] upd_addr;

  always #5 clk = ~clk;

  pt_walker dut_i (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [2];
  int nrd;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'd0;
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] frame, input logic [5:0] flags);
    return {frame, 4'b0, flags};
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Reference walk computed from the requirements.
  function automatic void ref_walk(input logic [31:0] va, input logic [1:0] acc,
      input logic [31:0] pt, output logic [31:0] pa, output logic [2:0] c,
      output bit up, output logic [31:0] ua, output int nr,
      output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    bit ok;
    a1 = pt + {18'd0, va[31:20], 2'b00};
    e1 = rd(a1); nr = 1; pa = 0; up = 0; ua = 0; a2 = 0;
    if (!e1[0]) begin c = 3'd1; return; end
    a2 = {e1[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    e2 = rd(a2); nr = 2; ua = a2;
    case (acc)
      2'd0: ok = e2[1];
      2'd1: ok = e2[2];
      2'd2: ok = e2[3];
      default: ok = 0;
    endcase
    if (!e2[0])                 c = 3'd2;
    else if (acc == 1 && e2[5]) c = 3'd4;
    else if (!ok)               c = 3'd3;
    else                        c = 3'd0;
    if (c == 0) pa = {e2[31:10], va[9:0]};
    up = (c == 0) && (acc == 1) && !e2[4];
  endfunction

  task automatic setup(input logic [31:0] va, input logic [31:0] pt,
                       input logic [31:0] e1, input logic [31:0] e2);
    mem.delete();
    mem[pt + {18'd0, va[31:20], 2'b00}] = e1;
    mem[{e1[31:10], 10'd0} + {20'd0, va[19:10], 2'b00}] = e2;
  endtask

  // Memory model with random stalls on both request and data.
  initial begin
    logic [31:0] a;
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rst_n && mem_rd_valid) begin
        a = mem_rd_addr;
        repeat ($urandom % 3) @(negedge clk);
        mem_rd_ready = 1;
        @(negedge clk);
        mem_rd_ready = 0;
        if (nrd < 2) rd_log[nrd] = a;
        nrd++;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_data  = rd(a);
        mem_rsp_valid = 1;
      end
    end
  end

  task automatic walk(input string r, input logic [31:0] va, input logic [1:0] acc,
                      input logic [31:0] pt, input bit poke_ptbr);
    logic [31:0] pa, ua, a1, a2, hold_pa;
    logic [2:0]  c;
    bit up;
    int nr;
    ref_walk(va, acc, pt, pa, c, up, ua, nr, a1, a2);
    nrd = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ptbr = pt; req_vaddr = va; req_acc = acc; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke_ptbr) ptbr = ~pt; // R2: must be ignored by the walk in flight
    while (!rsp_valid) @(negedge clk);
    check({r, " R10 cause"}, {29'd0, rsp_fault}, {29'd0, c});
    check({r, " R1 paddr"}, rsp_paddr, pa);
    check({r, " R8 upd_valid"}, {31'd0, upd_valid}, {31'd0, up});
    if (up) check({r, " R8 upd_addr"}, upd_addr, ua);
    check({r, " R4 reads"}, nrd, nr);
    check({r, " R2 l1 addr"}, rd_log[0], a1);
    if (nr == 2) check({r, " R3 l2 addr"}, rd_log[1], a2);
    hold_pa = rsp_paddr;
    repeat ($urandom % 3) @(negedge clk);
    check({r, " R9 held"}, {rsp_valid, rsp_paddr}, {1'b1, hold_pa});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    logic [31:0] va, pt;
    void'($urandom(32'd20240611));
    rst_n = 0; ptbr = 0; req_valid = 0; req_vaddr = 0; req_acc = 0; rsp_ready = 0; nrd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset ready", {31'd0, req_ready}, 32'd1);
    check("R9 reset idle", {29'd0, mem_rd_valid, rsp_valid, upd_valid}, 32'd0);

    va = 32'hABCD_E3FF; pt = 32'h0001_0000;
    setup(va, pt, mk(22'h00123, 6'b000000), mk(22'h1, 6'b001111));
    walk("R4 l1 invalid", va, 2'd0, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b001110));
    walk("R5 l2 invalid", va, 2'd0, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b000101));
    walk("R6 read no R", va, 2'd0, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b100111));
    walk("R7 cow with W", va, 2'd1, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b100011));
    walk("R7 cow no W", va, 2'd1, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b100011));
    walk("R7 cow read ok", va, 2'd0, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h3FFFFF, 6'b001001));
    walk("R1 exec ok", va, 2'd2, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b000101));
    walk("R8 write M clear", va, 2'd1, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b010101));
    walk("R8 write M set", va, 2'd1, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b001111));
    walk("R6 reserved acc", va, 2'd3, pt, 0);
    setup(va, pt, mk(22'h00123, 6'b000001), mk(22'h2A5, 6'b001111));
    walk("R2 ptbr change", va, 2'd0, pt, 1);
    va = 32'hFFFF_FFFF; pt = 32'hFFFF_F000;
    setup(va, pt, mk(22'h3FFFFF, 6'b000001), mk(22'h155, 6'b000011));
    walk("R2 base wrap", va, 2'd0, pt, 0);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] f1, f2;
      va = $urandom; pt = $urandom & 32'hFFFF_FFFC;
      f1 = 6'($urandom); f2 = 6'($urandom);
      f1[0] = ($urandom % 8) != 0;
      f2[0] = ($urandom % 8) != 0;
      setup(va, pt, mk(22'($urandom), f1), mk(22'($urandom), f2));
      walk("rand", va, 2'($urandom), pt, ($urandom % 4) == 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule